// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is the serial front end of a single digital potentiometer. It watches a two-wire bus (SCL, SDA) by sampling both lines with the system clock. It recognises start and stop conditions and accepts a slave address made of a fixed device-type nibble and four strapped address pins. It then decodes an instruction byte and runs the transaction that the opcode calls for. It drives SDA only through an open-drain enable and pulls the line low for acknowledges and for zero bits of read data.

Write-type commands are handed to the wiper latch and register store as a one-cycle strobe that carries opcode, register select and data. The strobe is issued on the stop that closes a complete transaction. Read commands return the current latch or a selected data register as one byte. An increment/decrement opcode switches the bus into a streaming mode in which every SCL pulse steps the wiper one tap. While the external nonvolatile store reports busy, the address is not acknowledged, which lets a master poll for completion.

Top module: `wiper_cmd_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0) and neither `cmd_valid_o` nor `step_o` pulses until a start and a valid transaction occur.
- R2: The address byte is acknowledged only when its upper nibble is 0101 and its lower nibble equals `addr_pins_i`; any other address gets no acknowledge and the bus is ignored until the next start.
- R3: The instruction byte is always acknowledged after a matched address; the opcode sits in bits 7:4, the register select in bits 3:2, and bits 1:0 have no effect.
- R4: Opcodes 1101 (register to latch), 1110 (latch to register), 0001 (all registers to latch) and 1000 (all latch to registers) finish after the instruction byte; the following stop produces one single-cycle `cmd_valid_o` with that opcode and register select.
- R5: Opcodes 1010 (write latch) and 1100 (write register) take a third byte, which is acknowledged; its bits 5:0 appear on `cmd_data_o` with the strobe issued at the closing stop, and its bits 7:6 have no effect.
- R6: Opcodes 1001 (read latch) and 1011 (read register) make the block send one byte, MSB first, equal to 00 followed by the 6-bit value (latch or the selected register), release SDA in the master's acknowledge slot, and issue no strobe.
- R7: Opcode 0010 enters stepping mode until a stop: each SCL pulse that completes with a falling edge gives one `step_o` pulse with `step_up_o` equal to the SDA level at the rising edge (1 = toward the high end); an SCL high phase ended by a stop gives no step.
- R8: While `nv_busy_i` is high the matching address byte is not acknowledged.
- R9: An unrecognised opcode is acknowledged, after which no further byte is acknowledged and no strobe is issued until the next start.
- R10: A start in the middle of any byte aborts the transaction and restarts address reception; a transaction cut short by a start or stop before its last acknowledge issues no strobe.
- R11: Bytes beyond a transaction's defined length are not acknowledged and do not change the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_pins_i | input | 4 | Strapped low address nibble |
| nv_busy_i | input | 1 | Nonvolatile store write in progress |
| latch_i | input | WIPER_W | Current wiper latch value for reads |
| regs_i | input | 4*WIPER_W | Four data register values, register n at bits n*WIPER_W |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the strobed command |
| cmd_reg_o | output | 2 | Register select of the strobed command |
| cmd_data_o | output | WIPER_W | Data of a write command |
| step_o | output | 1 | One-cycle wiper step pulse |
| step_up_o | output | 1 | Step direction, 1 toward the high terminal |

## Verification
Directed bus transactions drive every opcode class: two-byte transfers, three-byte writes with stray upper data bits and reserved instruction bits set, reads of both the latch and a non-zero register, and an unknown opcode followed by extra data. Address patterns that differ in the type nibble or in the pin nibble, and a correct address with the busy input high, separate the three acknowledge rules. Stepping runs mixed up and down pulses and closes with a stop, so an off-by-one on the last pulse shows in the step counts. Aborted transactions (a start inside a data byte, a stop before the data byte) show whether a strobe leaks from an incomplete command.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
package wcs_pkg;
  localparam logic [3:0] OP_RD_LATCH = 4'b1001;
  localparam logic [3:0] OP_WR_LATCH = 4'b1010;
  localparam logic [3:0] OP_RD_REG   = 4'b1011;
  localparam logic [3:0] OP_WR_REG   = 4'b1100;
  localparam logic [3:0] OP_REG2LAT  = 4'b1101;
  localparam logic [3:0] OP_LAT2REG  = 4'b1110;
  localparam logic [3:0] OP_GREG2LAT = 4'b0001;
  localparam logic [3:0] OP_GLAT2REG = 4'b1000;
  localparam logic [3:0] OP_STEP     = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_RX, ST_TX, ST_STEP, ST_HOLD, ST_IGNORE
  } state_e;

  typedef enum logic [2:0] {
    K_READ, K_WRITE, K_XFER, K_STEP, K_BAD
  } kind_e;

  function automatic kind_e op_kind(input logic [3:0] op);
    case (op)
      OP_RD_LATCH, OP_RD_REG:                           return K_READ;
      OP_WR_LATCH, OP_WR_REG:                           return K_WRITE;
      OP_REG2LAT, OP_LAT2REG, OP_GREG2LAT, OP_GLAT2REG: return K_XFER;
      OP_STEP:                                          return K_STEP;
      default:                                          return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/wcs_bus_sense.sv
`timescale 1ns/1ps
module wcs_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_i;
          sda_sync <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_sync[SYNC_STAGES-1];
      sda_p <= sda_sync[SYNC_STAGES-1];
    end

  logic scl_s;
  assign scl_s      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/wcs_bit_frame.sv
`timescale 1ns/1ps
module wcs_bit_frame #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_begin_o,
  output logic              ack_end_o,
  output logic              tx_fall_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      byte_o <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i) begin
      if (cnt_q < ACK_SLOT) byte_o <= {byte_o[BYTE_W-2:0], sda_i};
      if (cnt_q < ACK_DONE) cnt_q <= cnt_q + 1'b1;
    end else if (scl_fall_i && cnt_q == ACK_DONE) begin
      cnt_q <= '0;
    end

  // falls after bits 1..7 hand the next transmit bit to the line
  assign ack_begin_o = scl_fall_i && cnt_q == ACK_SLOT;
  assign ack_end_o   = scl_fall_i && cnt_q == ACK_DONE;
  assign tx_fall_o   = scl_fall_i && cnt_q != '0 && cnt_q < ACK_SLOT;
endmodule

// File: rtl/wiper_cmd_slave.sv
`timescale 1ns/1ps
module wiper_cmd_slave #(
  parameter int         WIPER_W     = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [3:0]           addr_pins_i,
  input  logic                 nv_busy_i,
  input  logic [WIPER_W-1:0]   latch_i,
  input  logic [4*WIPER_W-1:0] regs_i,
  output logic                 cmd_valid_o,
  output logic [3:0]           cmd_op_o,
  output logic [1:0]           cmd_reg_o,
  output logic [WIPER_W-1:0]   cmd_data_o,
  output logic                 step_o,
  output logic                 step_up_o
);
  import wcs_pkg::*;

  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - WIPER_W;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] rx_byte;
  logic ack_begin, ack_end, tx_fall;

  wcs_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  wcs_bit_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk_i, .rst_ni, .clear_i(start_ev),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .byte_o(rx_byte), .ack_begin_o(ack_begin), .ack_end_o(ack_end),
    .tx_fall_o(tx_fall)
  );

  state_e             st_q;
  logic [3:0]         op_q;
  logic [1:0]         sel_q;
  logic [WIPER_W-1:0] data_q;
  logic [BYTE_W-1:0]  tx_q;
  logic               pend_q, lvl_q, armed_q;

  logic addr_hit;
  assign addr_hit = rx_byte[7:4] == DEV_TYPE && rx_byte[3:0] == addr_pins_i && !nv_busy_i;

  logic [WIPER_W-1:0] rd_val;
  assign rd_val = (op_q == OP_RD_LATCH) ? latch_i : regs_i[sel_q*WIPER_W +: WIPER_W];

  logic [BYTE_W-1:0] rd_byte;
  assign rd_byte = {{PAD_W{1'b0}}, rd_val};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= '0;
      sel_q       <= '0;
      data_q      <= '0;
      tx_q        <= '0;
      pend_q      <= 1'b0;
      lvl_q       <= 1'b0;
      armed_q     <= 1'b0;
      sda_oe_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      step_o      <= 1'b0;
      step_up_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      step_o      <= 1'b0;
      if (start_ev) begin
        st_q     <= ST_ADDR;
        sda_oe_o <= 1'b0;
        pend_q   <= 1'b0;
        armed_q  <= 1'b0;
      end else if (stop_ev) begin
        cmd_valid_o <= (st_q == ST_HOLD) && pend_q;
        st_q        <= ST_IDLE;
        sda_oe_o    <= 1'b0;
        pend_q      <= 1'b0;
        armed_q     <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (ack_begin) begin
              if (addr_hit) sda_oe_o <= 1'b1;
              else          st_q     <= ST_IGNORE;
            end
            if (ack_end) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_INSTR;
            end
          end
          ST_INSTR: begin
            if (ack_begin) begin
              sda_oe_o <= 1'b1;
              op_q     <= rx_byte[7:4];
              sel_q    <= rx_byte[3:2];
            end
            if (ack_end) begin
              sda_oe_o <= 1'b0;
              unique case (op_kind(op_q))
                K_READ: begin
                  tx_q     <= rd_byte;
                  sda_oe_o <= ~rd_byte[BYTE_W-1];
                  st_q     <= ST_TX;
                end
                K_WRITE: st_q <= ST_RX;
                K_XFER: begin
                  pend_q <= 1'b1;
                  st_q   <= ST_HOLD;
                end
                K_STEP:  st_q <= ST_STEP;
                default: st_q <= ST_IGNORE;
              endcase
            end
          end
          ST_RX: begin
            if (ack_begin) begin
              sda_oe_o <= 1'b1;
              data_q   <= rx_byte[WIPER_W-1:0];
            end
            if (ack_end) begin
              sda_oe_o <= 1'b0;
              pend_q   <= 1'b1;
              st_q     <= ST_HOLD;
            end
          end
          ST_TX: begin
            if (tx_fall) begin
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~tx_q[BYTE_W-2];
            end
            if (ack_begin) sda_oe_o <= 1'b0;
            if (ack_end)   st_q     <= ST_HOLD;
          end
          ST_STEP: begin
            if (scl_rise) begin
              lvl_q   <= sda_s;
              armed_q <= 1'b1;
            end else if (scl_fall && armed_q) begin
              step_o    <= 1'b1;
              step_up_o <= lvl_q;
              armed_q   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end

  assign cmd_op_o   = op_q;
  assign cmd_reg_o  = sel_q;
  assign cmd_data_o = data_q;
endmodule

// File: rtl/wcs_checks.sv
`timescale 1ns/1ps
module wcs_checks (
  input logic            clk_i,
  input logic            rst_ni,
  input wcs_pkg::state_e st_i,
  input logic            sda_oe_o,
  input logic            nv_busy_i,
  input logic            cmd_valid_o,
  input logic            step_o
);
  import wcs_pkg::*;

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && st_i == ST_ADDR) |-> !$past(nv_busy_i)); // R8

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R4

  AST_CMD_FROM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(st_i) == ST_HOLD); // R10

  AST_CMD_LINE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !sda_oe_o); // R5

  AST_STEP_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(st_i) == ST_STEP); // R7

  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_IGNORE |-> !sda_oe_o); // R9

  AST_STEP_NOT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !cmd_valid_o); // R7
endmodule

bind wiper_cmd_slave wcs_checks u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_q), .sda_oe_o(sda_oe_o),
  .nv_busy_i(nv_busy_i), .cmd_valid_o(cmd_valid_o), .step_o(step_o)
);

// File: tb/tb_wiper_cmd_slave.sv
`timescale 1ns/1ps
module tb_wiper_cmd_slave;
  localparam int W    = 6;
  localparam int HALF = 20;
  localparam logic [3:0] PINS = 4'hA;
  localparam logic [7:0] ADDR_B = {4'b0101, PINS};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [W-1:0] latch = 6'h2D;
  logic [4*W-1:0] regs = {6'h3C, 6'h11, 6'h05, 6'h22};
  logic sda_oe, cmd_valid, step, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [W-1:0] cmd_data;
  wire sda_w = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  wiper_cmd_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .addr_pins_i(PINS), .nv_busy_i(busy), .latch_i(latch), .regs_i(regs),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_data_o(cmd_data), .step_o(step), .step_up_o(step_up)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_up = 0, n_dn = 0;
  logic [3:0] l_op; logic [1:0] l_reg; logic [W-1:0] l_data;

  always @(posedge clk) begin
    if (cmd_valid) begin n_cmd++; l_op = cmd_op; l_reg = cmd_reg; l_data = cmd_data; end
    if (step) begin if (step_up) n_up++; else n_dn++; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(); repeat (HALF) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw(); hw();
  endtask

  task automatic clk_bit(input logic b);
    m_sda = b; hw(); scl = 1'b1; hw(); scl = 1'b0; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    m_sda = 1'b1; hw(); scl = 1'b1; hw();
    ack = !sda_w;
    scl = 1'b0; hw();
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit held);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1; hw(); b[i] = sda_w; scl = 1'b0;
    end
    hw(); scl = 1'b1; hw(); held = sda_oe; scl = 1'b0; hw();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    check(n_cmd == 0 && n_up + n_dn == 0, "R1 no strobes", n_cmd + n_up + n_dn, 0);
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start(); send_byte({4'b0101, 4'h3}, a); bus_stop();
    check(!a, "R2 pin mismatch nack", a, 0);
    bus_start(); send_byte({4'b0111, PINS}, a); bus_stop();
    check(!a, "R2 type mismatch nack", a, 0);
  endtask

  task automatic t_write_latch();
    bit a0, a1, a2; int c0 = n_cmd;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'hA3, a1); send_byte(8'hD7, a2); bus_stop();
    check(a0 && a1 && a2, "R5 write acks", {a0, a1, a2}, 3'b111);
    check(n_cmd == c0 + 1, "R5 one strobe", n_cmd - c0, 1);
    check(l_op == 4'b1010 && l_data == 6'h17, "R5 op/data", {l_op, 2'b00, l_data}, {4'b1010, 8'h17});
  endtask

  task automatic t_write_reg();
    bit a0, a1, a2, a3; int c0 = n_cmd;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'hCB, a1); send_byte(8'h2A, a2);
    send_byte(8'h15, a3); bus_stop();
    check(a1, "R3 instr ack", a1, 1);
    check(l_reg == 2'd2 && l_op == 4'b1100, "R3 reg select, reserved ignored", {l_op, l_reg}, {4'b1100, 2'd2});
    check(!a3, "R11 extra byte nack", a3, 0);
    check(n_cmd == c0 + 1 && l_data == 6'h2A, "R11 pending data kept", l_data, 6'h2A);
  endtask

  task automatic t_reads();
    bit a0, a1, h; logic [7:0] b; int c0 = n_cmd;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'h90, a1); recv_byte(b, h); bus_stop();
    check(b == {2'b00, latch}, "R6 read latch", b, {2'b00, latch});
    check(!h, "R6 released in master ack slot", h, 0);
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'hBC, a1); recv_byte(b, h); bus_stop();
    check(b == {2'b00, regs[3*W +: W]}, "R6 read reg3", b, {2'b00, regs[3*W +: W]});
    check(n_cmd == c0, "R6 no strobe", n_cmd - c0, 0);
  endtask

  task automatic t_xfers();
    bit a0, a1; int c0;
    logic [3:0] ops [4] = '{4'b1101, 4'b1110, 4'b0001, 4'b1000};
    for (int k = 0; k < 4; k++) begin
      c0 = n_cmd;
      bus_start(); send_byte(ADDR_B, a0); send_byte({ops[k], 2'(k), 2'b00}, a1); bus_stop();
      check(n_cmd == c0 + 1 && l_op == ops[k] && l_reg == 2'(k), "R4 two-byte strobe",
            {l_op, l_reg}, {ops[k], 2'(k)});
    end
  endtask

  task automatic t_step();
    bit a0, a1; int u0 = n_up, d0 = n_dn;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'h20, a1);
    clk_bit(1); clk_bit(1); clk_bit(0); clk_bit(1); clk_bit(0);
    bus_stop();
    check(n_up - u0 == 3, "R7 up steps", n_up - u0, 3);
    check(n_dn - d0 == 2, "R7 down steps, none on stop", n_dn - d0, 2);
  endtask

  task automatic t_busy();
    bit a;
    busy = 1'b1;
    bus_start(); send_byte(ADDR_B, a); bus_stop();
    check(!a, "R8 busy nack", a, 0);
    busy = 1'b0;
    bus_start(); send_byte(ADDR_B, a); bus_stop();
    check(a, "R8 idle ack", a, 1);
  endtask

  task automatic t_unknown();
    bit a0, a1, a2; int c0 = n_cmd;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'h30, a1); send_byte(8'h3F, a2); bus_stop();
    check(a1, "R9 unknown op acked", a1, 1);
    check(!a2 && n_cmd == c0, "R9 then ignored", {a2, 4'(n_cmd - c0)}, 0);
  endtask

  task automatic t_abort();
    bit a0, a1; int c0 = n_cmd;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'hA0, a1);
    clk_bit(1); clk_bit(0); clk_bit(1);
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'hD4, a1); bus_stop();
    check(n_cmd == c0 + 1 && l_op == 4'b1101 && l_reg == 2'd1, "R10 mid-byte start", {l_op, l_reg}, {4'b1101, 2'd1});
    c0 = n_cmd;
    bus_start(); send_byte(ADDR_B, a0); send_byte(8'hC0, a1); bus_stop();
    check(n_cmd == c0, "R10 short write no strobe", n_cmd - c0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_write_latch();
    t_write_reg();
    t_reads();
    t_xfers();
    t_step();
    t_busy();
    t_unknown();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule